// File: doc/BRIEF.md
# Dual-Gain Sample Selector and Word Serializer

The block takes three 12-bit sample streams from the fast readout paths of a calorimeter front end. The paths carry the same pulse at low, medium and high gain, and each gain is eight times the one below it. The outgoing link has room for only two words per sample. The block therefore always sends the medium-gain word. It then sends one extra word, which is the high-gain word unless the high gain is saturated, and the low-gain word in that case. A flag beside the bus tells the receiver which of the two extra gains it got. The choice is made again for every sample, with no memory of earlier samples.

Samples arrive on a sample strobe that runs at half the rate of the word clock, and the strobe is synchronous to that clock. Each captured sample leaves as two consecutive words on one 12-bit bus: the medium word first, then the extra word. A frame marker is high in the cycle that carries the medium word. The saturation level is a build-time parameter, and its default is full scale (4095). A code of 4095 always counts as saturated. The strobe must be high for single cycles, with at least one idle cycle between strobes.

Top module: `gainsel_mux`

## Requirements
- R1: After a synchronous active-low reset, `word_out`, `lowgain_flag` and `frame_start` are all 0. `frame_start` stays 0 until a sample has been captured.
- R2: A sample captured at clock edge E appears as its medium-gain word on `word_out` after edge E+2. In that same cycle `frame_start` is 1, and this is the only cycle of the sample in which it is 1.
- R3: After edge E+3 `word_out` carries the high-gain word and `lowgain_flag` is 0, provided the high-gain code is below the saturation level and is not 4095.
- R4: If the high-gain code equals 4095, then after edge E+3 `word_out` carries the low-gain word and `lowgain_flag` is 1.
- R5: With `SAT_LEVEL` set below 4095, a high-gain code equal to or above `SAT_LEVEL` selects the low-gain word. A code one below `SAT_LEVEL` selects the high-gain word.
- R6: The gain choice depends only on the sample it belongs to. Samples sent back to back, one strobe every second cycle, alternate between low and high selection with no lag, and each sample still leaves as medium word then extra word.
- R7: `lowgain_flag` changes only in the cycle right after a `frame_start` cycle. It keeps its value through the medium word of the next sample.
- R8: While no strobe arrives, `frame_start` stays 0 and `word_out` holds the last word it sent.
- R9: `frame_start` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, high for one cycle per sample |
| lo_smp | input | 12 | Low-gain sample code |
| med_smp | input | 12 | Medium-gain sample code |
| hi_smp | input | 12 | High-gain sample code |
| word_out | output | 12 | Serialized output word |
| frame_start | output | 1 | High while `word_out` carries the medium word |
| lowgain_flag | output | 1 | 1 when the extra word is low gain, 0 when it is high gain |

## Verification
The bench sets the high-gain code exactly at the saturation level, one code below it, and at full scale. A comparator that is off by one, or that tests only for full scale, picks the wrong extra word at one of these points. A second instance built with a lower level checks the threshold path. Back-to-back samples that switch between saturated and unsaturated catch a design whose choice lags by one sample, or whose flag moves off the second word. Idle gaps after a sample catch a design that raises a false frame marker or lets the bus drift when no new sample has come in.

// File: rtl/gsm_pkg.sv
// Package for the dual-gain selector.
// Holds the sample width and the record passed from the select stage
// to the serializer. Assumes every gain path uses the same code width.
package gsm_pkg;
    parameter int GSM_DW = 12;
    localparam logic [GSM_DW-1:0] GSM_FULL = {GSM_DW{1'b1}};

    // One selected sample: the word that always goes out and the extra word
    typedef struct packed {
        logic [GSM_DW-1:0] med;
        logic [GSM_DW-1:0] xtra;
        logic              lowsel;
    } gsm_pair_t;
endpackage

// File: rtl/gsm_sat_detect.sv
// Saturation detector for the high-gain code.
// Flags a code as saturated when it is full scale, or when it is at or
// above SAT_LEVEL. If SAT_LEVEL is full scale, only the all-ones test is
// built. Purely combinational.
module gsm_sat_detect
    import gsm_pkg::*;
#(
    parameter int SAT_LEVEL = 4095
) (
    input  logic [GSM_DW-1:0] hi_code,
    output logic              is_sat
);
    localparam int FULL_INT = (1 << GSM_DW) - 1;
    localparam logic [GSM_DW-1:0] LEVEL = GSM_DW'(SAT_LEVEL);

    generate
        if (SAT_LEVEL >= FULL_INT) begin : g_full_only
            // Only full scale counts as saturated
            always_comb is_sat = &hi_code;
        end else begin : g_threshold
            // Full scale, or any code at or above the programmed level
            always_comb is_sat = (&hi_code) | (hi_code >= LEVEL);
        end
    endgenerate
endmodule

// File: rtl/gsm_sel_stage.sv
// Capture and select stage.
// Registers the three gain codes on the sample strobe. One cycle later it
// registers the medium word, the extra word and the low-gain flag, and
// pulses pair_vld. Assumes the strobe is high for one cycle at a time.
module gsm_sel_stage
    import gsm_pkg::*;
#(
    parameter int SAT_LEVEL = 4095
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [GSM_DW-1:0] lo_smp,
    input  logic [GSM_DW-1:0] med_smp,
    input  logic [GSM_DW-1:0] hi_smp,
    output gsm_pair_t         pair,
    output logic              pair_vld
);
    logic [GSM_DW-1:0] lo_q, med_q, hi_q;
    logic              cap_vld;
    logic              hi_sat;

    gsm_sat_detect #(.SAT_LEVEL(SAT_LEVEL)) u_sat (
        .hi_code (hi_q),
        .is_sat  (hi_sat)
    );

    // Capture the three gain codes on the sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            med_q   <= '0;
            hi_q    <= '0;
            cap_vld <= 1'b0;
        end else begin
            cap_vld <= smp_vld;
            if (smp_vld) begin
                lo_q  <= lo_smp;
                med_q <= med_smp;
                hi_q  <= hi_smp;
            end
        end
    end

    // Choose the extra word for the captured sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair     <= '0;
            pair_vld <= 1'b0;
        end else begin
            pair_vld <= cap_vld;
            if (cap_vld) begin
                pair.med    <= med_q;
                pair.xtra   <= hi_sat ? lo_q : hi_q;
                pair.lowsel <= hi_sat;
            end
        end
    end
endmodule

// File: rtl/gsm_word_mux.sv
// Two-slot word serializer.
// On pair_vld it puts the medium word on the bus and raises the frame
// marker. In the next cycle it sends the extra word and updates the gain
// flag. When idle, the bus holds its last value. Assumes pair_vld never
// comes in two consecutive cycles.
module gsm_word_mux
    import gsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  gsm_pair_t         pair,
    input  logic              pair_vld,
    output logic [GSM_DW-1:0] word_out,
    output logic              frame_start,
    output logic              lowgain_flag
);
    logic [GSM_DW-1:0] xtra_hold;
    logic              lowsel_hold;
    logic              second_due;

    // Send the medium word first, then the held extra word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out     <= '0;
            frame_start  <= 1'b0;
            lowgain_flag <= 1'b0;
            xtra_hold    <= '0;
            lowsel_hold  <= 1'b0;
            second_due   <= 1'b0;
        end else if (pair_vld) begin
            word_out    <= pair.med;
            frame_start <= 1'b1;
            xtra_hold   <= pair.xtra;
            lowsel_hold <= pair.lowsel;
            second_due  <= 1'b1;
        end else if (second_due) begin
            word_out     <= xtra_hold;
            lowgain_flag <= lowsel_hold;
            frame_start  <= 1'b0;
            second_due   <= 1'b0;
        end else begin
            frame_start <= 1'b0;
        end
    end
endmodule

// File: rtl/gainsel_mux.sv
// Top level of the dual-gain selector.
// Takes three gain codes per sample strobe. For each sample it sends the
// medium word and one extra word (high gain, or low gain if the high gain
// is saturated) on one bus at twice the sample rate. The medium word leaves
// two cycles after capture. Assumes at least one idle cycle between strobes.
module gainsel_mux
    import gsm_pkg::*;
#(
    parameter int SAT_LEVEL = 4095
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [GSM_DW-1:0] lo_smp,
    input  logic [GSM_DW-1:0] med_smp,
    input  logic [GSM_DW-1:0] hi_smp,
    output logic [GSM_DW-1:0] word_out,
    output logic              frame_start,
    output logic              lowgain_flag
);
    gsm_pair_t pair;
    logic      pair_vld;

    gsm_sel_stage #(.SAT_LEVEL(SAT_LEVEL)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .lo_smp   (lo_smp),
        .med_smp  (med_smp),
        .hi_smp   (hi_smp),
        .pair     (pair),
        .pair_vld (pair_vld)
    );

    gsm_word_mux u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .pair         (pair),
        .pair_vld     (pair_vld),
        .word_out     (word_out),
        .frame_start  (frame_start),
        .lowgain_flag (lowgain_flag)
    );
endmodule

// File: rtl/gsm_chk.sv
// Property checker for gainsel_mux, bound to every instance.
// Relates the top-level ports over time. Assumes strobes are spaced by at
// least one idle cycle.
module gsm_chk
    import gsm_pkg::*;
#(
    parameter int SAT_LEVEL = 4095
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic [GSM_DW-1:0] lo_smp,
    input logic [GSM_DW-1:0] med_smp,
    input logic [GSM_DW-1:0] hi_smp,
    input logic [GSM_DW-1:0] word_out,
    input logic              frame_start,
    input logic              lowgain_flag
);
    localparam logic [GSM_DW-1:0] LEVEL = GSM_DW'(SAT_LEVEL);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (word_out == '0 && !frame_start && !lowgain_flag));

    // R2
    med_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_vld, 3) && $past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1))
        |-> (frame_start && word_out == $past(med_smp, 3)));

    // R4
    extra_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_vld, 4) && $past(rst_n, 4) && $past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1))
        |-> (lowgain_flag == ((&$past(hi_smp, 4)) || ($past(hi_smp, 4) >= LEVEL))
             && word_out == (lowgain_flag ? $past(lo_smp, 4) : $past(hi_smp, 4))));

    // R7
    flag_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_start) && $past(rst_n)) |-> $stable(lowgain_flag));

    // R9
    single_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
endmodule

bind gainsel_mux gsm_chk #(.SAT_LEVEL(SAT_LEVEL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_vld      (smp_vld),
    .lo_smp       (lo_smp),
    .med_smp      (med_smp),
    .hi_smp       (hi_smp),
    .word_out     (word_out),
    .frame_start  (frame_start),
    .lowgain_flag (lowgain_flag)
);

// File: tb/gainsel_mux_tb.sv
// Directed bench for gainsel_mux, plus a second instance with a lower saturation level.
module gainsel_mux_tb;
    localparam time CLK_PERIOD = 12.5ns;
    localparam int  THR_LEVEL  = 3000;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] lo_smp = '0, med_smp = '0, hi_smp = '0;
    logic [11:0] word_out, word_thr;
    logic        frame_start, frame_thr, lowgain_flag, flag_thr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gainsel_mux u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .lo_smp(lo_smp), .med_smp(med_smp), .hi_smp(hi_smp),
        .word_out(word_out), .frame_start(frame_start), .lowgain_flag(lowgain_flag)
    );

    gainsel_mux #(.SAT_LEVEL(THR_LEVEL)) u_dut_thr (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .lo_smp(lo_smp), .med_smp(med_smp), .hi_smp(hi_smp),
        .word_out(word_thr), .frame_start(frame_thr), .lowgain_flag(flag_thr)
    );

    function automatic bit want_low(input logic [11:0] hi, input int level);
        return (hi == 12'hFFF) || (int'(hi) >= level);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One isolated sample: checks both slots on both instances
    task automatic send_one(input string req, input logic [11:0] lo, input logic [11:0] med,
                            input logic [11:0] hi);
        bit el = want_low(hi, 4095);
        bit et = want_low(hi, THR_LEVEL);
        @(negedge clk);
        smp_vld = 1'b1; lo_smp = lo; med_smp = med; hi_smp = hi;
        @(negedge clk);
        smp_vld = 1'b0; lo_smp = ~lo; med_smp = ~med; hi_smp = ~hi;
        @(negedge clk);
        @(negedge clk);
        check("R2", "medium word", int'(word_out), int'(med));
        check("R2", "frame marker", int'(frame_start), 1);
        check("R5", "thr medium word", int'(word_thr), int'(med));
        @(negedge clk);
        check("R9", "frame marker second slot", int'(frame_start), 0);
        check(req, "extra word", int'(word_out), int'(el ? lo : hi));
        check(req, "gain flag", int'(lowgain_flag), int'(el));
        check("R5", "thr extra word", int'(word_thr), int'(et ? lo : hi));
        check("R5", "thr gain flag", int'(flag_thr), int'(et));
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "word after reset", int'(word_out), 0);
        check("R1", "flag after reset", int'(lowgain_flag), 0);
        check("R1", "frame after reset", int'(frame_start), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1", "frame before first sample", int'(frame_start), 0);
        end
    endtask

    task automatic test_basic();
        send_one("R3", 12'd10, 12'd200, 12'd1600);
        send_one("R4", 12'd512, 12'd4000, 12'hFFF);
        send_one("R3", 12'd0, 12'd0, 12'd4094);
    endtask

    task automatic test_threshold();
        send_one("R5", 12'd30, 12'd375, 12'd3000);
        send_one("R5", 12'd31, 12'd374, 12'd2999);
        send_one("R5", 12'd400, 12'd3200, 12'd3500);
    endtask

    // Back-to-back samples, one strobe every other cycle
    task automatic test_stream();
        logic [11:0] lo_a[4]  = '{12'd11, 12'd22, 12'd33, 12'd44};
        logic [11:0] med_a[4] = '{12'd101, 12'd202, 12'd303, 12'd404};
        logic [11:0] hi_a[4]  = '{12'hFFF, 12'd800, 12'hFFF, 12'd900};
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (c >= 3 && c % 2 == 1 && (c - 3) / 2 < 4) begin
                check("R6", "stream medium", int'(word_out), int'(med_a[(c-3)/2]));
                check("R6", "stream frame", int'(frame_start), 1);
                if (c > 3)
                    check("R7", "flag held in medium slot", int'(lowgain_flag),
                          int'(want_low(hi_a[(c-5)/2], 4095)));
            end
            if (c >= 4 && c % 2 == 0 && (c - 4) / 2 < 4) begin
                bit el = want_low(hi_a[(c-4)/2], 4095);
                check("R6", "stream extra", int'(word_out),
                      int'(el ? lo_a[(c-4)/2] : hi_a[(c-4)/2]));
                check("R6", "stream flag", int'(lowgain_flag), int'(el));
            end
            if (c % 2 == 0 && c / 2 < 4) begin
                smp_vld = 1'b1; lo_smp = lo_a[c/2]; med_smp = med_a[c/2]; hi_smp = hi_a[c/2];
            end else begin
                smp_vld = 1'b0;
            end
        end
    endtask

    task automatic test_idle();
        send_one("R4", 12'd77, 12'd1234, 12'hFFF);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8", "idle frame", int'(frame_start), 0);
            check("R8", "idle bus hold", int'(word_out), 77);
            check("R7", "idle flag hold", int'(lowgain_flag), 1);
        end
    endtask

    initial begin
        test_reset();
        test_basic();
        test_threshold();
        test_stream();
        test_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule